// File: doc/BRIEF.md
# Supply Lockout and Soft-Start Sequencer

This block sits between the external enable pins of a power-management die and its regulators. It watches a digitized reading of the raw input supply and declares the supply good or bad with hysteresis. While the supply is bad, every regulator enable it drives is held low, whatever the pins request. Two kinds of regulator are served: step-down converters (bucks), which need a soft start, and linear regulators, which are simply gated.

A buck starts only on a low-to-high transition of its pin that is seen while the supply is already good. It then walks its switch current limit up a fixed, non-uniform four-step ladder. Each of the three lower steps is held for a programmable number of step-clock ticks, and the top step is the normal running limit. A buck that is off asks for its low-side switch to be turned on, so that its output is discharged. Losing the pin or the supply at any point drops the buck back to that off state, and the next qualifying edge starts the ladder again from the bottom.

Top module: `supply_lockout_seq`

## Requirements
- R1: The supply level code (20 mV per LSB) sets supply-good one cycle after a sample strictly above RISE_TH (default 145, 2.9 V). It clears it one cycle after a sample strictly below FALL_TH (default 135, 2.7 V). Samples from FALL_TH to RISE_TH inclusive leave the state unchanged. Supply-good is low after reset.
- R2: While supply-good is low, all bits of `en_out` are 0, regardless of `en_pin`.
- R3: A buck (en_pin bits 0 to N_BUCK-1) turns on one cycle after a clock edge that samples its pin high, where the previous sample was low and supply-good was high. When it turns on, its current-limit code is 0.
- R4: Current-limit codes 0, 1, 2 and 3 stand for 250 mA, 500 mA, 950 mA and 2 A, and buck b uses bits `ilim[2b+1:2b]`. Codes 0, 1 and 2 are each held for STEP_TICKS pulses of `step_tick`, and the limit then advances by one. Code 3 is held for as long as the buck stays on.
- R5: A buck that is off drives `dischg[b]` to 1 and `ilim` to code 0. A buck that is on drives `dischg[b]` to 0.
- R6: A buck whose pin goes low, or whose supply-good drops, during soft start or running is off at the next sample. Its next start begins again at code 0, even if a step tick arrived in the same cycle as the abort.
- R7: A buck pin that is already high when supply-good rises does not start that buck. The pin must go low and then high again.
- R8: A linear regulator enable (en_pin bits N_BUCK and up) follows its pin, gated only by supply-good, with no edge requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_lvl | input | LVL_W | Digitized input-supply level (level variant) |
| sup_above | input | 1 | Comparator flag: supply above the rising threshold (flag variant) |
| sup_below | input | 1 | Comparator flag: supply below the falling threshold (flag variant) |
| en_pin | input | N_BUCK+N_LDO | External enable requests, bucks first |
| step_tick | input | 1 | Soft-start step-clock pulse, one clk wide |
| en_out | output | N_BUCK+N_LDO | Gated regulator enables |
| ilim | output | 2*N_BUCK | Per-buck current-limit code |
| dischg | output | N_BUCK | Per-buck low-side discharge request |

## Verification
The final step tick of a ladder step and an abort can land on the same clock edge. So can a qualifying enable edge and a change of supply-good. The bench raises `step_tick` and lowers the buck pin on the same cycle. It then checks that the buck is off and that a fresh start shows code 0 rather than an advanced code. It also drops the supply while a buck is mid-ladder and confirms that the enable falls at once. Re-raising the supply must not restart the buck while its pin stays high.

// File: rtl/lockout_seq_pkg.sv
package lockout_seq_pkg;
   typedef enum logic [1:0] {SS_OFF, SS_RAMP, SS_RUN} ss_state_t;
   typedef logic [1:0] ilim_code_t;
   localparam ilim_code_t ILIM_FIRST = 2'd0;
   localparam ilim_code_t ILIM_LAST_RAMP = 2'd2;
endpackage

// File: rtl/supply_hyst.sv
module supply_hyst #(
   parameter int LVL_W     = 8,
   parameter int RISE_TH   = 145,
   parameter int FALL_TH   = 135,
   parameter bit USE_FLAGS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] lvl,
   input  logic             flag_above,
   input  logic             flag_below,
   output logic             good
);
   logic set_c, clr_c;

   if (USE_FLAGS) begin : g_flags
      logic [LVL_W-1:0] unused_lvl;
      assign unused_lvl = lvl;
      assign set_c = flag_above;
      assign clr_c = flag_below;
   end else begin : g_level
      localparam logic [LVL_W-1:0] RISE_C = LVL_W'(RISE_TH);
      localparam logic [LVL_W-1:0] FALL_C = LVL_W'(FALL_TH);
      logic unused_flags;
      assign unused_flags = flag_above ^ flag_below;
      assign set_c = (lvl > RISE_C);
      assign clr_c = (lvl < FALL_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                good <= 1'b0;
      else if (!good && set_c)   good <= 1'b1;
      else if (good && clr_c)    good <= 1'b0;
   end
endmodule

// File: rtl/buck_softstart.sv
module buck_softstart
   import lockout_seq_pkg::*;
#(
   parameter int STEP_TICKS = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       good,
   input  logic       en_pin,
   input  logic       tick,
   output logic       on,
   output ilim_code_t ilim
);
   localparam int CNT_W = (STEP_TICKS > 2) ? $clog2(STEP_TICKS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_TICKS - 1);

   ss_state_t        st;
   ilim_code_t       step;
   logic [CNT_W-1:0] cnt;
   logic             pin_q;
   logic             keep;

   assign keep = en_pin && good;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SS_OFF;
         step  <= ILIM_FIRST;
         cnt   <= '0;
         pin_q <= 1'b0;
      end else begin
         pin_q <= en_pin;
         case (st)
            SS_OFF: begin
               step <= ILIM_FIRST;
               cnt  <= '0;
               if (en_pin && !pin_q && good) st <= SS_RAMP;
            end
            SS_RAMP: begin
               if (!keep) begin
                  st   <= SS_OFF;
                  step <= ILIM_FIRST;
                  cnt  <= '0;
               end else if (tick) begin
                  if (cnt == CNT_LAST) begin
                     cnt  <= '0;
                     step <= step + 2'd1;
                     if (step == ILIM_LAST_RAMP) st <= SS_RUN;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (!keep) begin
                  st   <= SS_OFF;
                  step <= ILIM_FIRST;
                  cnt  <= '0;
               end
            end
         endcase
      end
   end

   assign on   = (st != SS_OFF);
   assign ilim = step;
endmodule

// File: rtl/supply_lockout_seq.sv
module supply_lockout_seq
   import lockout_seq_pkg::*;
#(
   parameter int LVL_W      = 8,
   parameter int RISE_TH    = 145,
   parameter int FALL_TH    = 135,
   parameter bit USE_FLAGS  = 1'b0,
   parameter int N_BUCK     = 2,
   parameter int N_LDO      = 2,
   parameter int STEP_TICKS = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LVL_W-1:0]          sup_lvl,
   input  logic                      sup_above,
   input  logic                      sup_below,
   input  logic [N_BUCK+N_LDO-1:0]   en_pin,
   input  logic                      step_tick,
   output logic [N_BUCK+N_LDO-1:0]   en_out,
   output logic [2*N_BUCK-1:0]       ilim,
   output logic [N_BUCK-1:0]         dischg
);
   localparam int N_REG = N_BUCK + N_LDO;

   if (FALL_TH >= RISE_TH) begin : g_bad_th
      initial $error("supply_lockout_seq: FALL_TH must be below RISE_TH");
   end
   if (STEP_TICKS < 2) begin : g_bad_step
      initial $error("supply_lockout_seq: STEP_TICKS must be at least 2");
   end
   if (N_BUCK < 1) begin : g_bad_nb
      initial $error("supply_lockout_seq: N_BUCK must be at least 1");
   end

   logic good_w;

   supply_hyst #(
      .LVL_W(LVL_W), .RISE_TH(RISE_TH), .FALL_TH(FALL_TH), .USE_FLAGS(USE_FLAGS)
   ) u_hyst (
      .clk(clk), .rst_n(rst_n), .lvl(sup_lvl),
      .flag_above(sup_above), .flag_below(sup_below), .good(good_w)
   );

   for (genvar b = 0; b < N_BUCK; b++) begin : g_buck
      logic       seq_on;
      ilim_code_t seq_ilim;
      buck_softstart #(.STEP_TICKS(STEP_TICKS)) u_ss (
         .clk(clk), .rst_n(rst_n), .good(good_w), .en_pin(en_pin[b]),
         .tick(step_tick), .on(seq_on), .ilim(seq_ilim)
      );
      assign en_out[b]       = seq_on && good_w;
      assign ilim[2*b +: 2]  = en_out[b] ? seq_ilim : ILIM_FIRST;
      assign dischg[b]       = !en_out[b];
   end

   for (genvar k = N_BUCK; k < N_REG; k++) begin : g_ldo
      assign en_out[k] = en_pin[k] && good_w;
   end
endmodule

// File: rtl/lockout_seq_chk.sv
module lockout_seq_chk #(
   parameter int N_BUCK = 2,
   parameter int N_REG  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                good,
   input logic [N_REG-1:0]    en_pin,
   input logic [N_REG-1:0]    en_out,
   input logic [2*N_BUCK-1:0] ilim,
   input logic [N_BUCK-1:0]   dischg
);
   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !good |-> (en_out == '0)); // R2

   for (genvar b = 0; b < N_BUCK; b++) begin : g_b
      AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(en_out[b]) |-> ($past(en_pin[b]) && $past(good) && ilim[2*b +: 2] == 2'd0)); // R3
      AST_LADDER_UP: assert property (@(posedge clk) disable iff (!rst_n)
         (en_out[b] && $past(en_out[b])) |->
            (ilim[2*b +: 2] >= $past(ilim[2*b +: 2]) &&
             ilim[2*b +: 2] - $past(ilim[2*b +: 2]) <= 2'd1)); // R4
      AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
         (en_out[b] && !en_pin[b]) |=> !en_out[b]); // R6
      AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_out[b] && dischg[b]) |=> (!en_out[b] || ilim[2*b +: 2] == 2'd0)); // R5
   end
endmodule

bind supply_lockout_seq lockout_seq_chk #(.N_BUCK(N_BUCK), .N_REG(N_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .good(good_w), .en_pin(en_pin),
   .en_out(en_out), .ilim(ilim), .dischg(dischg)
);

// File: tb/sim_supply_lockout_seq.sv
module sim_supply_lockout_seq;
   localparam int ST = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sup_lvl = 8'd0;
   logic       sup_above = 1'b0;
   logic       sup_below = 1'b0;
   logic [3:0] en_pin = 4'b0;
   logic       step_tick = 1'b0;
   logic [3:0] en_out;
   logic [3:0] ilim;
   logic [1:0] dischg;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   supply_lockout_seq #(.STEP_TICKS(ST)) u0 (
      .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl), .sup_above(sup_above),
      .sup_below(sup_below), .en_pin(en_pin), .step_tick(step_tick),
      .en_out(en_out), .ilim(ilim), .dischg(dischg)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=%0d expected<=20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc1();
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         step_tick = 1'b1;
         @(negedge clk);
         step_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk("R2 reset en_out", en_out, 0);
      chk("R5 reset dischg", dischg, 3);
      chk("R5 reset ilim", ilim, 0);
   endtask

   task automatic t_hyst_ldo();
      en_pin[2] = 1'b1;
      sup_lvl = 8'd145; cyc1(); cyc1();
      chk("R1 at rise threshold stays bad", en_out[2], 0);
      sup_lvl = 8'd146; cyc1();
      chk("R1 above rise -> good, R8 ldo on", en_out[2], 1);
      en_pin[3] = 1'b1; #1;
      chk("R8 ldo3 follows pin level", en_out[3], 1);
      sup_lvl = 8'd135; cyc1(); cyc1();
      chk("R1 at fall threshold stays good", en_out[2], 1);
      sup_lvl = 8'd134; cyc1();
      chk("R1 below fall -> bad, R2 lockout", en_out, 0);
      sup_lvl = 8'd140; cyc1();
      chk("R1 between thresholds holds bad", en_out[3], 0);
      en_pin[3:2] = 2'b00;
   endtask

   task automatic t_already_high();
      en_pin[0] = 1'b1; cyc1(); cyc1();
      chk("R2 buck pin high, supply bad", en_out[0], 0);
      sup_lvl = 8'd150; cyc1(); cyc1();
      chk("R7 pin already high does not start", en_out[0], 0);
      chk("R5 off buck discharges", dischg[0], 1);
      en_pin[0] = 1'b0; cyc1();
      en_pin[0] = 1'b1; cyc1();
      chk("R3 fresh edge starts buck", en_out[0], 1);
      chk("R3 start at code 0", ilim[1:0], 0);
      chk("R5 on buck no discharge", dischg[0], 0);
   endtask

   task automatic t_ladder();
      ticks(ST - 1);
      chk("R4 code 0 held before last tick", ilim[1:0], 0);
      ticks(1);
      chk("R4 advance to code 1", ilim[1:0], 1);
      ticks(ST);
      chk("R4 advance to code 2", ilim[1:0], 2);
      ticks(ST);
      chk("R4 advance to code 3", ilim[1:0], 3);
      ticks(3 * ST);
      chk("R4 code 3 held while running", ilim[1:0], 3);
      chk("R5 other buck still off", ilim[3:2], 0);
   endtask

   task automatic t_abort();
      en_pin[0] = 1'b0; cyc1();
      chk("R6 pin low stops buck", en_out[0], 0);
      chk("R5 stopped buck discharges", dischg[0], 1);
      en_pin[0] = 1'b1; cyc1();
      chk("R6 restart from code 0", ilim[1:0], 0);
      ticks(ST);
      chk("R4 restarted ladder moves", ilim[1:0], 1);
      sup_lvl = 8'd100; cyc1();
      chk("R6 supply loss stops buck", en_out[0], 0);
      sup_lvl = 8'd150; cyc1(); cyc1();
      chk("R7 no restart with pin held high", en_out[0], 0);
      en_pin[0] = 1'b0; cyc1();
      en_pin[0] = 1'b1; cyc1();
      chk("R6 restart after supply loss at code 0", ilim[1:0], 0);
   endtask

   task automatic t_same_cycle();
      ticks(ST - 1);
      step_tick = 1'b1; en_pin[0] = 1'b0;
      cyc1();
      step_tick = 1'b0;
      chk("R6 abort wins over final tick", en_out[0], 0);
      en_pin[0] = 1'b1; cyc1();
      chk("R6 code 0 after tick+abort", ilim[1:0], 0);
      en_pin[1] = 1'b1; cyc1();
      ticks(ST);
      chk("R4 buck1 ladder independent", ilim[3:2], 1);
      chk("R4 buck0 advanced with shared ticks", ilim[1:0], 1);
   endtask

   initial begin
      cyc1(); cyc1();
      t_reset();
      rst_n = 1'b1;
      cyc1();
      t_hyst_ldo();
      t_already_high();
      t_ladder();
      t_abort();
      t_same_cycle();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule